// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block delivers inter-processor software interrupts among a small cluster of CPUs. Any CPU can post one of sixteen software interrupt IDs to a set of target CPUs with a single 32-bit register write. For every (target CPU, ID) pair the block keeps a bitmap of the source CPUs that have asked for that interrupt. The pending output for that pair is high while the bitmap is non-empty.

Each CPU retires its software interrupts through its own acknowledge port. An acknowledge names an ID. It returns that ID with the number of the lowest pending source packed above it, and it removes only that one source. The interrupt therefore stays pending until every requesting source has been served. Software can also inspect a source bitmap, add bits to it or remove bits from it through per-ID byte registers. Choosing which ID to acknowledge is left to the logic around the block.

Top module: `sgi_dispatch`

## Requirements
- R1: After a synchronous reset all source bitmaps are empty, `pend`, `ack_valid` and `bus_rdata` are zero, and `ack_data` is zero.
- R2: A write to address 0xF00 is a dispatch. In the written word, bits 9:0 give the ID, bits 23:16 give the target list (only the low NCPU bits are used) and bits 25:24 give the filter. For each selected target, bit `bus_cpu` is set in that target's bitmap for the ID. `pend[target*NID+ID]` is high after the next rising edge.
- R3: The filter values select targets as follows: 0 takes the target list, 1 takes every CPU except the requester, 2 takes only the requester, and 3 takes every CPU.
- R4: A dispatch whose ID is NID or above, or whose resolved target set is empty, changes no bitmap and no pending bit.
- R5: When `ack_req[c]` is high with `ack_id` slice c = ID and that bitmap is non-empty, `ack_valid[c]` is high one edge later. `ack_data` slice c (13 bits) then holds the ID in bits 9:0 and the lowest set source number in bits 12:10, and that source bit is cleared.
- R6: A pending bit stays high while any source remains and falls at the same edge at which the last source is removed. With no bus write, no pending bit rises.
- R7: An acknowledge of an empty bitmap returns 1023 (source field zero) with `ack_valid` high, and it changes no state.
- R8: A write to address 0xF10+ID clears the bits of `bus_wdata[NCPU-1:0]` from the requester's bitmap for that ID.
- R9: A write to address 0xF20+ID ORs `bus_wdata[NCPU-1:0]` into the requester's bitmap for that ID. A write of zero bits leaves the pending bit unchanged.
- R10: A read at address 0xF10+ID or 0xF20+ID returns the requester's bitmap for that ID, as it stood before the edge, zero-extended on `bus_rdata` one edge later. All other cycles return zero.
- R11: When an acknowledge and a set hit the same bitmap in one cycle, the result is the bitmap after the acknowledge clear, ORed with the newly set bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPUW | Number of the CPU issuing the access |
| bus_rdata | output | 8 | Registered read data |
| ack_req | input | NCPU | Per-CPU acknowledge request |
| ack_id | input | NCPU*IDW | Per-CPU ID to acknowledge |
| ack_valid | output | NCPU | Per-CPU acknowledge return valid |
| ack_data | output | NCPU*13 | Per-CPU acknowledge return: source in 12:10, ID in 9:0 |
| pend | output | NCPU*NID | Pending bit of target t, ID i at t*NID+i |

## Verification
Every result of this block comes from a register loaded at the rising edge that samples the stimulus. Pending bits, acknowledge returns and read data are all due exactly one edge after the cycle in which the write, acknowledge or read is presented. The bench drives inputs on the falling edge and updates its behavioural bitmap model at the rising edge. It compares every output on the following falling edge, so each check lands on the first cycle the result may appear. The directed checks read outputs at that same falling edge, right after the driving task returns.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam logic [11:0] OFF_DISPATCH = 12'hF00;
  localparam logic [11:0] OFF_SRC_CLR  = 12'hF10;
  localparam logic [11:0] OFF_SRC_SET  = 12'hF20;
  localparam int unsigned RET_ID_W  = 10;
  localparam int unsigned RET_SRC_W = 3;
  localparam int unsigned RET_W     = RET_ID_W + RET_SRC_W;
  localparam logic [RET_W-1:0] RET_NONE = RET_W'(1023);

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_ALL    = 2'd3
  } filter_e;
endpackage

// File: rtl/sgi_bus_decode.sv
module sgi_bus_decode import sgi_pkg::*; #(
  parameter int NCPU = 4,
  parameter int NID  = 16,
  localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IDW  = (NID > 1) ? $clog2(NID) : 1
) (
  input  logic                                   bus_we,
  input  logic                                   bus_re,
  input  logic [11:0]                            bus_addr,
  input  logic [31:0]                            bus_wdata,
  input  logic [CPUW-1:0]                        bus_cpu,
  output logic [NCPU-1:0][NID-1:0][NCPU-1:0]     set_o,
  output logic [NCPU-1:0][NID-1:0][NCPU-1:0]     clr_o,
  output logic                                   rd_hit_o,
  output logic [IDW-1:0]                         rd_id_o
);
  logic [NCPU-1:0] req_bit;
  logic [NCPU-1:0] tgt_mask;
  logic [9:0]      disp_id;
  filter_e         filt;
  logic [11:0]     clr_off;
  logic [11:0]     set_off;
  logic            in_clr;
  logic            in_set;

  assign req_bit = NCPU'(1) << bus_cpu;
  assign disp_id = bus_wdata[9:0];
  assign filt    = filter_e'(bus_wdata[25:24]);
  assign clr_off = bus_addr - OFF_SRC_CLR;
  assign set_off = bus_addr - OFF_SRC_SET;
  assign in_clr  = clr_off < 12'(NID);
  assign in_set  = set_off < 12'(NID);

  always_comb begin
    case (filt)
      FLT_LIST:   tgt_mask = bus_wdata[16 +: NCPU];
      FLT_OTHERS: tgt_mask = ~req_bit;
      FLT_SELF:   tgt_mask = req_bit;
      default:    tgt_mask = '1;
    endcase
  end

  always_comb begin
    set_o = '0;
    clr_o = '0;
    if (bus_we && bus_addr == OFF_DISPATCH && disp_id < 10'(NID)) begin
      for (int t = 0; t < NCPU; t++) begin
        if (tgt_mask[t]) set_o[t][disp_id[IDW-1:0]] = req_bit;
      end
    end
    if (bus_we && in_clr) clr_o[bus_cpu][clr_off[IDW-1:0]] = bus_wdata[NCPU-1:0];
    if (bus_we && in_set) set_o[bus_cpu][set_off[IDW-1:0]] = bus_wdata[NCPU-1:0];
  end

  assign rd_hit_o = bus_re && (in_clr || in_set);
  assign rd_id_o  = in_clr ? clr_off[IDW-1:0] : set_off[IDW-1:0];
endmodule

// File: rtl/sgi_ack_unit.sv
module sgi_ack_unit import sgi_pkg::*; #(
  parameter int NCPU = 4,
  parameter int NID  = 16,
  localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IDW  = (NID > 1) ? $clog2(NID) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NID-1:0][NCPU-1:0]       map_i,
  input  logic                           req_i,
  input  logic [IDW-1:0]                 id_i,
  output logic [NID-1:0][NCPU-1:0]       clr_o,
  output logic                           valid_o,
  output logic [RET_W-1:0]               data_o
);
  logic [NCPU-1:0] row;
  logic            found;
  logic [CPUW-1:0] src;
  logic [RET_W-1:0] ret;

  assign row = map_i[id_i];

  // lowest-numbered source wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    src   = '0;
    for (int s = NCPU - 1; s >= 0; s--) begin
      if (row[s]) begin
        found = 1'b1;
        src   = CPUW'(s);
      end
    end
  end

  always_comb begin
    clr_o = '0;
    if (req_i && found) clr_o[id_i][src] = 1'b1;
  end

  assign ret = found ? {RET_SRC_W'(src), RET_ID_W'(id_i)} : RET_NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) data_o <= ret;
    end
  end
endmodule

// File: rtl/sgi_src_store.sv
module sgi_src_store #(
  parameter int NCPU = 4,
  parameter int NID  = 16,
  localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IDW  = (NID > 1) ? $clog2(NID) : 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NCPU-1:0][NID-1:0][NCPU-1:0] set_i,
  input  logic [NCPU-1:0][NID-1:0][NCPU-1:0] clr_i,
  input  logic [NCPU-1:0][NID-1:0][NCPU-1:0] ack_clr_i,
  input  logic                               rd_hit_i,
  input  logic [CPUW-1:0]                    rd_cpu_i,
  input  logic [IDW-1:0]                     rd_id_i,
  output logic [NCPU-1:0][NID-1:0][NCPU-1:0] map_o,
  output logic [NCPU*NID-1:0]                pend_o,
  output logic [7:0]                         rdata_o
);
  logic [NCPU-1:0][NID-1:0][NCPU-1:0] map_q;
  logic [NCPU-1:0][NID-1:0][NCPU-1:0] map_nxt;
  logic [NCPU*NID-1:0]                pend_nxt;

  // clears (bus and acknowledge) act on the old bitmap, new requests win
  assign map_nxt = (map_q & ~clr_i & ~ack_clr_i) | set_i;

  for (genvar t = 0; t < NCPU; t++) begin : g_tgt
    for (genvar i = 0; i < NID; i++) begin : g_id
      assign pend_nxt[t*NID + i] = |map_nxt[t][i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q   <= '0;
      pend_o  <= '0;
      rdata_o <= '0;
    end else begin
      map_q   <= map_nxt;
      pend_o  <= pend_nxt;
      rdata_o <= rd_hit_i ? 8'(map_q[rd_cpu_i][rd_id_i]) : 8'h00;
    end
  end

  assign map_o = map_q;
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch import sgi_pkg::*; #(
  parameter int NCPU = 4,
  parameter int NID  = 16,
  localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IDW  = (NID > 1) ? $clog2(NID) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_we,
  input  logic                    bus_re,
  input  logic [11:0]             bus_addr,
  input  logic [31:0]             bus_wdata,
  input  logic [CPUW-1:0]         bus_cpu,
  output logic [7:0]              bus_rdata,
  input  logic [NCPU-1:0]         ack_req,
  input  logic [NCPU*IDW-1:0]     ack_id,
  output logic [NCPU-1:0]         ack_valid,
  output logic [NCPU*RET_W-1:0]   ack_data,
  output logic [NCPU*NID-1:0]     pend
);
  logic [NCPU-1:0][NID-1:0][NCPU-1:0] bus_set;
  logic [NCPU-1:0][NID-1:0][NCPU-1:0] bus_clr;
  logic [NCPU-1:0][NID-1:0][NCPU-1:0] ack_clr;
  logic [NCPU-1:0][NID-1:0][NCPU-1:0] src_map;
  logic                               rd_hit;
  logic [IDW-1:0]                     rd_id;

  sgi_bus_decode #(.NCPU(NCPU), .NID(NID)) u_dec (
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_cpu  (bus_cpu),
    .set_o    (bus_set),
    .clr_o    (bus_clr),
    .rd_hit_o (rd_hit),
    .rd_id_o  (rd_id)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_ack
    sgi_ack_unit #(.NCPU(NCPU), .NID(NID)) u_ack (
      .clk    (clk),
      .rst    (rst),
      .map_i  (src_map[c]),
      .req_i  (ack_req[c]),
      .id_i   (ack_id[c*IDW +: IDW]),
      .clr_o  (ack_clr[c]),
      .valid_o(ack_valid[c]),
      .data_o (ack_data[c*RET_W +: RET_W])
    );
  end

  sgi_src_store #(.NCPU(NCPU), .NID(NID)) u_store (
    .clk      (clk),
    .rst      (rst),
    .set_i    (bus_set),
    .clr_i    (bus_clr),
    .ack_clr_i(ack_clr),
    .rd_hit_i (rd_hit),
    .rd_cpu_i (bus_cpu),
    .rd_id_i  (rd_id),
    .map_o    (src_map),
    .pend_o   (pend),
    .rdata_o  (bus_rdata)
  );
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NCPU = 4,
  parameter int NID  = 16,
  localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IDW  = (NID > 1) ? $clog2(NID) : 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_we,
  input logic                  bus_re,
  input logic [11:0]           bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [CPUW-1:0]       bus_cpu,
  input logic [7:0]            bus_rdata,
  input logic [NCPU-1:0]       ack_req,
  input logic [NCPU-1:0]       ack_valid,
  input logic [NCPU*13-1:0]    ack_data,
  input logic [NCPU*NID-1:0]   pend
);
  logic is_disp;
  int   self_idx;

  assign is_disp  = bus_we && bus_addr == 12'hF00;
  assign self_idx = int'(bus_cpu) * NID + int'(bus_wdata[IDW-1:0]);

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    p_ack_after_req_r5: assert property (@(posedge clk) disable iff (rst)
      ack_valid[c] |-> $past(ack_req[c]));
    p_none_no_src_r7: assert property (@(posedge clk) disable iff (rst)
      (ack_valid[c] && ack_data[c*13 +: 10] == 10'h3FF) |-> ack_data[c*13+10 +: 3] == 3'd0);
  end

  p_bad_id_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (is_disp && bus_wdata[9:0] >= 10'(NID) && ack_req == '0) |=> $stable(pend));

  p_self_pends_r3: assert property (@(posedge clk) disable iff (rst)
    (is_disp && bus_wdata[25:24] == 2'd2 && bus_wdata[9:0] < 10'(NID)) |=> pend[$past(self_idx)]);

  p_no_rise_without_write_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> (pend & ~$past(pend)) == '0);

  p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> bus_rdata == 8'h00);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU), .NID(NID)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
  .ack_req(ack_req), .ack_valid(ack_valid), .ack_data(ack_data), .pend(pend)
);

// File: tb/tb_sgi_dispatch.sv
module tb_sgi_dispatch;
  localparam int  NCPU = 4;
  localparam int  NID  = 16;
  localparam int  IDW  = 4;
  localparam time CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bus_we = 1'b0;
  logic               bus_re = 1'b0;
  logic [11:0]        bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [1:0]         bus_cpu = '0;
  logic [7:0]         bus_rdata;
  logic [NCPU-1:0]    ack_req = '0;
  logic [NCPU*IDW-1:0] ack_id = '0;
  logic [NCPU-1:0]    ack_valid;
  logic [NCPU*13-1:0] ack_data;
  logic [NCPU*NID-1:0] pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgi_dispatch #(.NCPU(NCPU), .NID(NID)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
    .ack_req(ack_req), .ack_id(ack_id), .ack_valid(ack_valid),
    .ack_data(ack_data), .pend(pend)
  );

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R1";
  bit    done   = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [3:0]  mmap [4][16];
  logic [3:0]  nm   [4][16];
  logic [3:0]  e_valid;
  logic [12:0] e_data [4];
  logic [7:0]  e_rdata;
  logic [3:0]  m_row, m_tgt;
  int          m_id, m_src;
  logic [11:0] m_a;

  always @(posedge clk) begin
    if (rst) begin
      foreach (mmap[t, i]) mmap[t][i] = 4'h0;
      e_valid = 4'h0;
      foreach (e_data[c]) e_data[c] = 13'h0;
      e_rdata = 8'h00;
    end else begin
      nm = mmap;
      for (int c = 0; c < NCPU; c++) begin
        e_valid[c] = ack_req[c];
        if (ack_req[c]) begin
          m_id  = int'(ack_id[c*IDW +: IDW]);
          m_row = mmap[c][m_id];
          if (m_row != 0) begin
            m_src = 0;
            while (!m_row[m_src]) m_src++;
            e_data[c] = 13'(m_id) | 13'(m_src << 10);
            nm[c][m_id][m_src] = 1'b0;
          end else begin
            e_data[c] = 13'd1023;
          end
        end
      end
      m_a = bus_addr;
      if (bus_re && m_a >= 12'hF10 && m_a < 12'hF30) e_rdata = {4'h0, mmap[bus_cpu][m_a[3:0]]};
      else e_rdata = 8'h00;
      if (bus_we) begin
        if (m_a == 12'hF00 && bus_wdata[9:0] < 10'd16) begin
          case (bus_wdata[25:24])
            2'd0: m_tgt = bus_wdata[19:16];
            2'd1: m_tgt = 4'hF & ~(4'h1 << bus_cpu);
            2'd2: m_tgt = 4'h1 << bus_cpu;
            default: m_tgt = 4'hF;
          endcase
          for (int t = 0; t < NCPU; t++)
            if (m_tgt[t]) nm[t][bus_wdata[3:0]][bus_cpu] = 1'b1;
        end else if (m_a >= 12'hF10 && m_a < 12'hF20) begin
          nm[bus_cpu][m_a[3:0]] = nm[bus_cpu][m_a[3:0]] & ~bus_wdata[3:0];
        end else if (m_a >= 12'hF20 && m_a < 12'hF30) begin
          nm[bus_cpu][m_a[3:0]] = nm[bus_cpu][m_a[3:0]] | bus_wdata[3:0];
        end
      end
      mmap = nm;
    end
  end

  logic [NCPU*NID-1:0] e_pend;
  always @(negedge clk) begin
    if (!done) begin
      for (int t = 0; t < NCPU; t++)
        for (int i = 0; i < NID; i++) e_pend[t*NID + i] = |mmap[t][i];
      chk({phase, " pend"}, 64'(pend), 64'(e_pend));
      chk({phase, " ack_valid"}, 64'(ack_valid), 64'(e_valid));
      for (int c = 0; c < NCPU; c++)
        if (e_valid[c]) chk({phase, " ack_data"}, 64'(ack_data[c*13 +: 13]), 64'(e_data[c]));
      chk({phase, " rdata"}, 64'(bus_rdata), 64'(e_rdata));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] c);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = c;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] c);
    bus_re = 1'b1; bus_addr = a; bus_cpu = c;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic ack(input int c, input logic [3:0] id);
    ack_req[c] = 1'b1; ack_id[c*IDW +: IDW] = id;
    @(negedge clk);
    ack_req = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  logic [NCPU*NID-1:0] snap;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pend", 64'(pend), 64'h0);
    chk("R1 ack_valid", 64'(ack_valid), 64'h0);
    chk("R1 rdata", 64'(bus_rdata), 64'h0);

    phase = "R2";
    wr(12'hF00, 32'h000A_0005, 2'd0);
    chk("R2 t1", 64'(pend[1*16+5]), 64'h1);
    chk("R2 t3", 64'(pend[3*16+5]), 64'h1);
    chk("R2 t0", 64'(pend[0*16+5]), 64'h0);
    wr(12'hF00, 32'h0008_0005, 2'd2);

    phase = "R10";
    rd(12'hF15, 2'd3);
    chk("R10 clr-view", 64'(bus_rdata), 64'h5);
    rd(12'hF25, 2'd3);
    chk("R10 set-view", 64'(bus_rdata), 64'h5);
    rd(12'hF30, 2'd3);
    chk("R10 outside", 64'(bus_rdata), 64'h0);

    phase = "R5";
    ack(3, 4'd5);
    chk("R5 first", 64'(ack_data[3*13 +: 13]), 64'h5);
    chk("R6 still pending", 64'(pend[3*16+5]), 64'h1);
    ack(3, 4'd5);
    chk("R5 second", 64'(ack_data[3*13 +: 13]), 64'h805);
    chk("R6 drained", 64'(pend[3*16+5]), 64'h0);
    phase = "R7";
    ack(3, 4'd5);
    chk("R7 empty", 64'(ack_data[3*13 +: 13]), 64'd1023);

    phase = "R3";
    wr(12'hF00, 32'h0100_0007, 2'd1);
    chk("R3 others", 64'({pend[3*16+7], pend[2*16+7], pend[1*16+7], pend[7]}), 64'hD);
    wr(12'hF00, 32'h0200_0009, 2'd3);
    chk("R3 self", 64'({pend[3*16+9], pend[2*16+9], pend[1*16+9], pend[9]}), 64'h8);
    wr(12'hF00, 32'h0300_000F, 2'd0);
    chk("R3 all", 64'({pend[3*16+15], pend[2*16+15], pend[1*16+15], pend[15]}), 64'hF);

    phase = "R4";
    snap = pend;
    wr(12'hF00, 32'h000F_0014, 2'd0);
    chk("R4 id range", 64'(pend), 64'(snap));
    wr(12'hF00, 32'h0000_0002, 2'd0);
    chk("R4 empty list", 64'(pend), 64'(snap));
    wr(12'hF00, 32'h00F0_0002, 2'd0);
    chk("R4 high list bits", 64'(pend), 64'(snap));

    phase = "R8";
    wr(12'hF17, 32'h0000_0002, 2'd0);
    chk("R8 cleared", 64'(pend[7]), 64'h0);

    phase = "R9";
    snap = pend;
    wr(12'hF24, 32'h0000_0000, 2'd1);
    chk("R9 zero set", 64'(pend), 64'(snap));
    wr(12'hF23, 32'h0000_0009, 2'd2);
    chk("R9 pending", 64'(pend[2*16+3]), 64'h1);
    rd(12'hF13, 2'd2);
    chk("R9 readback", 64'(bus_rdata), 64'h9);

    phase = "R11";
    bus_we = 1'b1; bus_addr = 12'hF23; bus_wdata = 32'h1; bus_cpu = 2'd2;
    ack_req[2] = 1'b1; ack_id[2*IDW +: IDW] = 4'd3;
    @(negedge clk);
    bus_we = 1'b0; ack_req = '0;
    chk("R11 ack value", 64'(ack_data[2*13 +: 13]), 64'h3);
    rd(12'hF23, 2'd2);
    chk("R11 merged", 64'(bus_rdata), 64'h9);

    phase = "R2 mix";
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 5);
      bus_cpu   = 2'($urandom_range(0, 3));
      bus_wdata = {6'h0, 2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)),
                   6'h0, 10'($urandom_range(0, 19))};
      bus_we = (r <= 2);
      bus_re = (r == 3);
      bus_addr = (r == 0) ? 12'hF00 : (12'hF10 + 12'($urandom_range(0, 33)));
      ack_req = 4'($urandom_range(0, 15)) & {4{r >= 3}};
      ack_id  = 16'($urandom);
      @(negedge clk);
    end
    bus_we = 1'b0; bus_re = 1'b0; ack_req = '0;
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog actual=0 expected=1");
    finish_run();
  end
endmodule